// File: doc/BRIEF.md
# Banked Coefficient Store with Host Staging Registers

This block keeps 24-bit filter coefficients in three pages of 64 words each. A host reaches the store only through byte-wide registers. It loads a base address and up to five staged coefficients, then sets a strobe in a command register. The transfer between the staging registers and the store starts only on a rising edge of an audio frame clock. That clock is asynchronous, so it is brought into the system clock domain first. If the frame clock stops, the transfer waits.

A filter datapath reads the active page through its own port, one word per cycle. Changing the page register switches this port to the new page at once. The filter port has priority over the host. Whenever both want the store in the same cycle, the host transfer waits a cycle.

Top module: `coef_bank_ctrl`

## Requirements
- R1: After reset, the address register, the command register, the page register and all fifteen staging registers read 0.
- R2: The host register map is as follows. The base address is at 0x16 and holds 6 bits; the upper two bits read 0. Staging bytes are at 0x17 to 0x25. Byte 0x17+k belongs to coefficient k/3, and k%3 = 0, 1, 2 selects its top, middle and bottom byte. The command register is at 0x26. The page register is at 0x31 and holds bits 1:0. Every other address reads 0.
- R3: Command bit 0 (single write) writes staged coefficient 0 to the base address of the selected page.
- R4: Command bit 1 (set write) writes staged coefficients 0 to 4 to base+0 through base+4. The address wraps modulo 64.
- R5: Command bit 2 (single read) loads the word at the base address into staged coefficient 0. Staged coefficients 1 to 4 are left unchanged.
- R6: Command bit 3 (set read) loads the words at base+0 through base+4 into staged coefficients 0 to 4. The address wraps modulo 64.
- R7: A strobe reads back as 1 while its transfer is pending. The transfer starts only after a rising edge of the frame clock. The strobe clears itself when the transfer completes. While the frame clock is held still, the request stays pending indefinitely.
- R8: A command write with several bits set keeps only the highest of them, in the priority order bit 3, bit 2, bit 1, bit 0. A command write is ignored while a transfer is pending. Bits 7:4 read 0.
- R9: A page value of 3 reads back as 3 but addresses page 0.
- R10: When the filter read enable is high, the filter data output presents, on the following cycle, the word at the filter address in the page selected at that moment. A page change takes effect on the next filter read.
- R11: In any cycle where the filter read enable is high, the host transfer makes no progress. The transfer resumes once the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Asynchronous audio frame clock |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_rdata | output | 8 | Host read data, combinational from the address while the read strobe is high |
| flt_en | input | 1 | Filter read enable |
| flt_addr | input | 6 | Filter word address |
| flt_data | output | 24 | Filter read data, one cycle after the enable |

## Verification
A host transfer and a filter read can both claim the coefficient store in the same cycle. The bench provokes this by issuing a single write and holding the filter read enable high across the frame clock edge and for many cycles after it. It judges the outcome at the ports. During the stall, the filter output must still show the old word, and the strobe must still read 1. After the enable drops, the strobe clears and the filter output shows the new word.

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl #(
  parameter int DW    = 24,
  parameter int AW    = 6,
  parameter int NBANK = 3,
  parameter int NSET  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_clk,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  input  logic          flt_en,
  input  logic [AW-1:0] flt_addr,
  output logic [DW-1:0] flt_data
);
  localparam int DEPTH = 1 << AW;
  localparam int NB    = DW / 8;
  localparam int NREG  = NSET * NB;
  localparam int BW    = $clog2(NBANK);
  localparam int IW    = $clog2(NSET);
  localparam logic [7:0] A_BASE = 8'h16;
  localparam logic [7:0] A_DATA = 8'h17;
  localparam logic [7:0] A_CMD  = 8'h26;
  localparam logic [7:0] A_PAGE = 8'h31;

  logic [DW-1:0] mem [NBANK*DEPTH];
  logic [DW-1:0] stage [NSET];
  logic [AW-1:0] base;
  logic [3:0]    cmd;
  logic [1:0]    page;
  logic [IW-1:0] idx;
  logic          busy;
  logic [2:0]    fsync;

  wire           fr_rise = fsync[1] & ~fsync[2];
  wire [BW-1:0]  bank    = (page >= 2'(NBANK)) ? '0 : BW'(page);
  wire           op_rd   = cmd[3] | cmd[2];
  wire [IW-1:0]  last    = (cmd[3] | cmd[1]) ? IW'(NSET-1) : '0;
  wire [AW-1:0]  xaddr   = base + AW'(idx);
  wire           step    = busy & ~flt_en;
  wire [7:0]     doff    = reg_addr - A_DATA;
  wire           in_data = (reg_addr >= A_DATA) && (doff < 8'(NREG));

  function automatic logic [3:0] prio(input logic [3:0] v);
    if (v[3])      return 4'b1000;
    else if (v[2]) return 4'b0100;
    else if (v[1]) return 4'b0010;
    else           return {3'b000, v[0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) fsync <= '0;
    else        fsync <= {fsync[1:0], frame_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cmd  <= '0;
      page <= '0;
      busy <= 1'b0;
      idx  <= '0;
      for (int i = 0; i < NSET; i++) stage[i] <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == A_BASE) base <= reg_wdata[AW-1:0];
        if (reg_addr == A_PAGE) page <= reg_wdata[1:0];
        if (reg_addr == A_CMD && cmd == '0) cmd <= prio(reg_wdata[3:0]);
        if (in_data) stage[doff/NB][8*(NB-1-doff%NB) +: 8] <= reg_wdata;
      end
      if (!busy && fr_rise && cmd != '0) begin
        busy <= 1'b1;
        idx  <= '0;
      end
      if (step) begin
        if (op_rd) stage[idx] <= mem[int'(bank)*DEPTH + int'(xaddr)];
        if (idx == last) begin
          busy <= 1'b0;
          cmd  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step && !op_rd) mem[int'(bank)*DEPTH + int'(xaddr)] <= stage[idx];
    if (flt_en) flt_data <= mem[int'(bank)*DEPTH + int'(flt_addr)];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_BASE)      reg_rdata = 8'(base);
      else if (reg_addr == A_CMD)  reg_rdata = {4'b0, cmd};
      else if (reg_addr == A_PAGE) reg_rdata = {6'b0, page};
      else if (in_data)            reg_rdata = stage[doff/NB][8*(NB-1-doff%NB) +: 8];
    end
  end
endmodule

module coef_bank_ctrl_chk #(
  parameter int NSET = 5,
  parameter int IW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          flt_en,
  input logic          fr_rise,
  input logic [3:0]    cmd,
  input logic [IW-1:0] idx
);
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd)); // R8
  AST_FILTER_STALLS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    busy && flt_en |=> busy && $stable(idx)); // R11
  AST_WAIT_FOR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != '0 && !busy && !fr_rise |=> !busy && $stable(cmd)); // R7
  AST_BUSY_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cmd != '0); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cmd == '0); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx < IW'(NSET)); // R4
endmodule

bind coef_bank_ctrl coef_bank_ctrl_chk #(.NSET(NSET), .IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .flt_en(flt_en),
  .fr_rise(fr_rise), .cmd(cmd), .idx(idx));

// File: tb/test_coef_bank_ctrl.sv
module test_coef_bank_ctrl;
  logic clk = 0, rst_n = 0, frame_clk = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_wr = 0, reg_rd = 0, flt_en = 0;
  logic [5:0] flt_addr = 0;
  logic [23:0] flt_data;
  int checks = 0, fails = 0;
  logic [23:0] w [5];

  always #2 clk = ~clk;

  coef_bank_ctrl i_coef_bank_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata; reg_rd = 0;
  endtask

  task automatic frd(input logic [5:0] a, output logic [23:0] d);
    @(negedge clk); flt_addr = a; flt_en = 1;
    @(negedge clk); d = flt_data; flt_en = 0;
  endtask

  task automatic pulse();
    frame_clk = 1; repeat (6) @(negedge clk);
    frame_clk = 0; repeat (12) @(negedge clk);
  endtask

  task automatic stage_word(input int k, input logic [23:0] v);
    wr(8'h17 + 8'(3*k), v[23:16]);
    wr(8'h18 + 8'(3*k), v[15:8]);
    wr(8'h19 + 8'(3*k), v[7:0]);
  endtask

  task automatic read_word(input int k, output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(8'h17 + 8'(3*k), b0); rd(8'h18 + 8'(3*k), b1); rd(8'h19 + 8'(3*k), b2);
    v = {b0, b1, b2};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h16, d); chk("R1 base", d, 0);
    rd(8'h26, d); chk("R1 cmd", d, 0);
    rd(8'h31, d); chk("R1 page", d, 0);
    for (int k = 0; k < 15; k++) begin rd(8'h17 + 8'(k), d); chk("R1 stage", d, 0); end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(8'h16, 8'hFF); rd(8'h16, d); chk("R2 base width", d, 8'h3F);
    wr(8'h1A, 8'hA5); rd(8'h1A, d); chk("R2 stage byte", d, 8'hA5);
    wr(8'h31, 8'hFE); rd(8'h31, d); chk("R2 page width", d, 8'h02);
    rd(8'h40, d); chk("R2 unmapped", d, 0);
    wr(8'h1A, 8'h00);
  endtask

  task automatic t_single_write();
    logic [23:0] v;
    wr(8'h31, 1); wr(8'h16, 10); stage_word(0, 24'h123456);
    wr(8'h26, 8'h01); pulse();
    frd(10, v); chk("R3 single write", v, 24'h123456);
    wr(8'h31, 0); wr(8'h16, 10); stage_word(0, 24'hABCDEF);
    wr(8'h26, 8'h01); pulse();
    frd(10, v); chk("R3 page 0 word", v, 24'hABCDEF);
  endtask

  task automatic t_set_write();
    logic [23:0] v;
    wr(8'h31, 2); wr(8'h16, 62);
    for (int k = 0; k < 5; k++) begin w[k] = 24'h100001 * (k + 3); stage_word(k, w[k]); end
    wr(8'h26, 8'h02); pulse();
    for (int k = 0; k < 5; k++) begin
      frd(6'(62 + k), v); chk("R4 set write wrap", v, w[k]);
    end
  endtask

  task automatic t_single_read();
    logic [23:0] v;
    wr(8'h31, 1); wr(8'h16, 10); stage_word(0, 0); stage_word(1, 24'h0F0F0F);
    wr(8'h26, 8'h04); pulse();
    read_word(0, v); chk("R5 single read", v, 24'h123456);
    read_word(1, v); chk("R5 others kept", v, 24'h0F0F0F);
  endtask

  task automatic t_set_read();
    logic [23:0] v;
    for (int k = 0; k < 5; k++) stage_word(k, 0);
    wr(8'h31, 2); wr(8'h16, 62);
    wr(8'h26, 8'h08); pulse();
    for (int k = 0; k < 5; k++) begin read_word(k, v); chk("R6 set read", v, w[k]); end
  endtask

  task automatic t_pending();
    logic [7:0] d;
    logic [23:0] v;
    wr(8'h31, 1); wr(8'h16, 20); stage_word(0, 24'h777777);
    wr(8'h26, 8'h01); repeat (40) @(negedge clk);
    rd(8'h26, d); chk("R7 pending held", d, 8'h01);
    pulse();
    rd(8'h26, d); chk("R7 self clear", d, 0);
    frd(20, v); chk("R7 completed", v, 24'h777777);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(8'h26, 8'hF0); rd(8'h26, d); chk("R8 reserved", d, 0);
    wr(8'h26, 8'h0F); rd(8'h26, d); chk("R8 priority", d, 8'h08);
    wr(8'h26, 8'h01); rd(8'h26, d); chk("R8 ignored while pending", d, 8'h08);
    pulse();
    rd(8'h26, d); chk("R8 done", d, 0);
  endtask

  task automatic t_page3();
    logic [7:0] d;
    logic [23:0] v;
    wr(8'h31, 3); rd(8'h31, d); chk("R9 readback", d, 3);
    frd(10, v); chk("R9 maps to page 0", v, 24'hABCDEF);
  endtask

  task automatic t_switch();
    logic [23:0] v;
    wr(8'h31, 1); frd(10, v); chk("R10 page 1", v, 24'h123456);
    wr(8'h31, 0); frd(10, v); chk("R10 switched to page 0", v, 24'hABCDEF);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    logic [23:0] v;
    wr(8'h31, 2); wr(8'h16, 5); stage_word(0, 24'h0000AA);
    wr(8'h26, 8'h01); pulse();
    stage_word(0, 24'h0000BB); wr(8'h26, 8'h01);
    @(negedge clk); flt_addr = 5; flt_en = 1;
    pulse(); repeat (10) @(negedge clk);
    chk("R11 filter sees old word", flt_data, 24'h0000AA);
    rd(8'h26, d); chk("R11 host stalled", d, 8'h01);
    flt_en = 0; repeat (4) @(negedge clk);
    rd(8'h26, d); chk("R11 resumed", d, 0);
    frd(5, v); chk("R11 new word", v, 24'h0000BB);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk); rst_n = 1;
    t_reset(); t_regmap(); t_single_write(); t_set_write();
    t_single_read(); t_set_read(); t_pending(); t_priority();
    t_page3(); t_switch(); t_collision();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule